// File: doc/BRIEF.md
# PCI Target Address Translation Windows

This block maps an address arriving from a PCI bus target into the local-bus address space. It checks the address against three memory windows and one I/O window. When a window matches, it returns a hit flag, a one-hot window index and the translated address. Each memory window has a PCI-side base, a local-side base and a nine-bit mask over address bits 28:20. A masked bit is left out of the comparison and is copied unchanged into the translated address. An unmasked bit must match the PCI base and is replaced by the local base. The I/O window compares a fixed 24-bit prefix and swaps it for its local base.

The address is captured on `req_valid`, and the result appears one clock later with `rsp_valid`. A space-select input marks each request as I/O or memory, and only the windows of that kind are searched. Software loads the window settings through a write-only port: a 3-bit select and a 32-bit data word. Each window also has an enable bit. After reset every window is disabled.

Top module: `pci_xlate_win`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_win` and `rsp_addr` are 0, and every window is disabled, so any request misses until a window is enabled.
- R2: `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` high. `rsp_hit`, `rsp_win` and `rsp_addr` change only in that cycle and hold their values while no request arrives.
- R3: A memory window matches only if PCI address bits 31:29 equal its PCI base bits 31:29, which can never be masked, and, for each bit in 28:20 whose mask bit is 0, the address bit equals the base bit. Address bits whose mask bit is 1 are not compared.
- R4: On a memory hit, translated bits 31:29 come from the local base. Each translated bit in 28:20 comes from the local base when its mask bit is 0 and from the PCI address when it is 1. Translated bits 19:0 equal PCI address bits 19:0.
- R5: The I/O window matches when PCI address bits 31:8 equal its PCI base. The translated address is then the I/O local base in bits 31:8 with PCI address bits 7:0 below.
- R6: The I/O mask field is stored, but its value never changes I/O matching or translation.
- R7: A request with `req_is_io`=1 is checked only against the I/O window. A request with `req_is_io`=0 is checked only against the memory windows.
- R8: A window whose enable bit is 0 never matches.
- R9: When several memory windows match, the one with the lowest number is reported.
- R10: When no window matches, `rsp_hit`=0, `rsp_win`=0 and `rsp_addr`=0.
- R11: Register map, selected by `cfg_sel` on a `cfg_we` cycle:
  - Selects 0, 1 and 2 are the bases of memory window n: data[31:20] is the PCI base 31:20 and data[11:0] is the local base 31:20.
  - Selects 3, 4 and 5 are the controls of memory window n-3: data[28:20] is the mask and data[0] is the enable.
  - Select 6 holds the I/O PCI base in data[31:8] and the I/O enable in data[0].
  - Select 7 holds the I/O local base in data[31:8] and the I/O mask in data[7:0].
  - All other data bits are ignored.
- R12: `rsp_win` is one-hot or zero. Bit n (n = 0, 1, 2) marks memory window n, bit 3 marks the I/O window, and `rsp_hit` equals the OR of its bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_data | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe; captures the address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | PCI address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 4 | One-hot matching window |
| rsp_addr | output | 32 | Translated local-bus address |

## Verification
The assertions check, on every cycle, the structural rules at the outputs:
- the response follows the request by exactly one cycle;
- the window index is one-hot or zero and agrees with the hit flag;
- a miss returns a zero address;
- I/O and memory requests never report a window of the other kind;
- the low address bits pass through unchanged on a hit.

Only the bench's scenarios can show the rest, because each depends on programmed register contents:
- that the comparison uses the correct bits under a given mask;
- how the local base merges with the PCI address;
- which window wins when several match;
- that disabled windows, the I/O mask and unused register bits have no effect.

// File: rtl/pci_xlate_win.sv
module pci_xlate_win #(
  parameter int NMEM = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_data,
  input  logic        req_valid,
  input  logic        req_is_io,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [3:0]  rsp_win,
  output logic [31:0] rsp_addr
);

  localparam int WIDX = NMEM + 1;

  logic [NMEM-1:0]        mhit;
  logic [NMEM-1:0]        mwin;
  logic [NMEM-1:0][31:0]  mxl;

  logic [23:0] io_pb, io_lb;
  logic [7:0]  io_mk;
  logic        io_en;
  logic        ihit;

  logic             nhit;
  logic [WIDX-1:0]  nwin;
  logic [31:0]      naddr;

  for (genvar i = 0; i < NMEM; i++) begin : g_mem
    logic [11:0] pb, lb;
    logic [8:0]  mk;
    logic        en;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pb <= '0;
        lb <= '0;
        mk <= '0;
        en <= 1'b0;
      end else if (cfg_we && cfg_sel == 3'(i)) begin
        pb <= cfg_data[31:20];
        lb <= cfg_data[11:0];
      end else if (cfg_we && cfg_sel == 3'(i + 3)) begin
        mk <= cfg_data[28:20];
        en <= cfg_data[0];
      end
    end

    assign mhit[i] = en && (req_addr[31:29] == pb[11:9])
                        && ((req_addr[28:20] & ~mk) == (pb[8:0] & ~mk));
    assign mxl[i]  = {lb[11:9], (lb[8:0] & ~mk) | (req_addr[28:20] & mk),
                      req_addr[19:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_pb <= '0;
      io_lb <= '0;
      io_mk <= '0;
      io_en <= 1'b0;
    end else if (cfg_we && cfg_sel == 3'd6) begin
      io_pb <= cfg_data[31:8];
      io_en <= cfg_data[0];
    end else if (cfg_we && cfg_sel == 3'd7) begin
      io_lb <= cfg_data[31:8];
      io_mk <= cfg_data[7:0];
    end
  end

  assign ihit = io_en && (req_addr[31:8] == io_pb);
  assign mwin = mhit & (~mhit + 1'b1);

  always_comb begin
    naddr = '0;
    if (req_is_io) begin
      nwin = {ihit, {NMEM{1'b0}}};
      if (ihit) naddr = {io_lb, req_addr[7:0]};
    end else begin
      nwin = {1'b0, mwin};
      for (int i = 0; i < NMEM; i++)
        if (mwin[i]) naddr = naddr | mxl[i];
    end
  end

  assign nhit = |nwin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= nhit;
        rsp_win  <= nwin;
        rsp_addr <= naddr;
      end
    end
  end

endmodule

// File: rtl/pci_xlate_win_chk.sv
module pci_xlate_win_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_is_io,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [3:0]  rsp_win,
  input logic [31:0] rsp_addr
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr) && $stable(rsp_win));

  // R12
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_win) && (rsp_hit == (rsp_win != 4'd0)));

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_addr == 32'd0);

  // R7
  io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_is_io) |-> rsp_win[2:0] == 3'd0);

  // R7
  mem_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !$past(req_is_io) |-> !rsp_win[3]);

  // R4
  mem_low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && !rsp_win[3] |-> rsp_addr[19:0] == $past(req_addr[19:0]));

  // R5
  io_low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_win[3] |-> rsp_addr[7:0] == $past(req_addr[7:0]));

endmodule

bind pci_xlate_win pci_xlate_win_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_win(rsp_win), .rsp_addr(rsp_addr)
);

// File: tb/tb_pci_xlate_win.sv
module tb_pci_xlate_win;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_win;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad = 0;

  logic [11:0] s_pb [3];
  logic [11:0] s_lb [3];
  logic [8:0]  s_mk [3];
  logic        s_en [3];
  logic [23:0] s_iopb, s_iolb;
  logic        s_ioen;

  always #2 clk = ~clk;

  pci_xlate_win dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shadow_clear();
    for (int i = 0; i < 3; i++) begin
      s_pb[i] = '0; s_lb[i] = '0; s_mk[i] = '0; s_en[i] = 1'b0;
    end
    s_iopb = '0; s_iolb = '0; s_ioen = 1'b0;
  endtask

  // R11 register map, written and mirrored
  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0, 3'd1, 3'd2: begin s_pb[sel] = d[31:20]; s_lb[sel] = d[11:0]; end
      3'd3, 3'd4, 3'd5: begin s_mk[sel-3] = d[28:20]; s_en[sel-3] = d[0]; end
      3'd6: begin s_iopb = d[31:8]; s_ioen = d[0]; end
      default: s_iolb = d[31:8];
    endcase
  endtask

  function automatic logic [36:0] model(input logic [31:0] a, input logic io);
    logic [3:0]  w;
    logic [31:0] t;
    w = '0; t = '0;
    if (io) begin
      if (s_ioen && a[31:8] == s_iopb) begin
        w = 4'b1000; t = {s_iolb, a[7:0]};
      end
    end else begin
      for (int i = 2; i >= 0; i--) begin
        if (s_en[i] && a[31:29] == s_pb[i][11:9] &&
            (a[28:20] & ~s_mk[i]) == (s_pb[i][8:0] & ~s_mk[i])) begin
          w = 4'(1 << i);
          t = {s_lb[i][11:9], (s_lb[i][8:0] & ~s_mk[i]) | (a[28:20] & s_mk[i]), a[19:0]};
        end
      end
    end
    return {(w != 0), w, t};
  endfunction

  task automatic req(input logic [31:0] a, input logic io, input string tag);
    logic [36:0] e;
    e = model(a, io);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"},   32'(rsp_hit),   32'(e[36]));
    chk({tag, " win"},   32'(rsp_win),   32'(e[35:32]));
    chk({tag, " addr"},  rsp_addr,       e[31:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] last;
    seed = $urandom(32'h5eed_0042);
    shadow_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(rsp_valid), 0);
    chk("R1 hit", 32'(rsp_hit), 0);
    chk("R1 win", 32'(rsp_win), 0);
    chk("R1 addr", rsp_addr, 0);
    req(32'h0000_0000, 1'b0, "R1 mem miss after reset");
    req(32'h0000_0000, 1'b1, "R1 io miss after reset");

    // R8 base programmed but disabled
    wr(3'd0, 32'h4000_0123);
    req(32'h400A_BCDE, 1'b0, "R8 disabled");
    chk("R8 miss", 32'(rsp_hit), 0);
    wr(3'd3, 32'h0000_0001);
    req(32'h400A_BCDE, 1'b0, "R4 exact");
    chk("R4 literal", rsp_addr, 32'h123A_BCDE);
    chk("R12 literal win0", 32'(rsp_win), 32'h1);

    // R2 hold with no request
    last = rsp_addr;
    @(negedge clk);
    chk("R2 no valid", 32'(rsp_valid), 0);
    chk("R2 hold", rsp_addr, last);

    // R3 / R4 partial mask
    wr(3'd1, 32'h8000_0A00);
    wr(3'd4, 32'h0FF0_0001);
    req(32'h8FF1_2345, 1'b0, "R3 masked bits ignored");
    chk("R4 merge literal", rsp_addr, 32'hAFF1_2345);
    req(32'h9FF1_2345, 1'b0, "R3 unmasked bit28 compared");
    chk("R3 bit28 miss", 32'(rsp_hit), 0);

    // R3 full mask, top bits still compared
    wr(3'd2, 32'h2000_0E00);
    wr(3'd5, 32'h1FF0_0001);
    req(32'h3ABC_DEF0, 1'b0, "R3 full mask hit");
    chk("R4 full mask literal", rsp_addr, 32'hFABC_DEF0);
    req(32'h5ABC_DEF0, 1'b0, "R3 top bits never masked");
    chk("R3 top miss", 32'(rsp_hit), 0);

    // R9 priority
    wr(3'd1, 32'h4000_0777);
    wr(3'd4, 32'h0000_0001);
    req(32'h4001_0000, 1'b0, "R9 lowest wins");
    chk("R9 win0", 32'(rsp_win), 32'h1);
    wr(3'd3, 32'h0000_0000);
    req(32'h4001_0000, 1'b0, "R9 next window");
    chk("R9 win1", 32'(rsp_win), 32'h2);

    // R11 ignored bits
    wr(3'd3, 32'hE00F_FFFF);
    req(32'h4001_0000, 1'b0, "R11 junk ctrl bits");
    chk("R11 win0 enabled", 32'(rsp_win), 32'h1);
    wr(3'd0, 32'h400F_F123);
    req(32'h400A_BCDE, 1'b0, "R11 junk base bits");

    // R5 / R6 / R7 I/O
    wr(3'd6, 32'h00C0_DE01);
    wr(3'd7, 32'h7F00_0000);
    req(32'h00C0_DE5A, 1'b1, "R5 io hit");
    chk("R5 literal", rsp_addr, 32'h7F00_005A);
    chk("R12 io bit", 32'(rsp_win), 32'h8);
    wr(3'd7, 32'h7F00_00FF);
    req(32'h00C0_DE5A, 1'b1, "R6 mask no effect");
    chk("R6 literal", rsp_addr, 32'h7F00_005A);
    req(32'h00C0_DF5A, 1'b1, "R6 mask not compared");
    chk("R6 miss", 32'(rsp_hit), 0);
    req(32'h00C0_DE5A, 1'b0, "R7 io addr as mem");
    chk("R7 mem no io", 32'(rsp_win[3]), 0);
    req(32'h400A_BCDE, 1'b1, "R7 mem addr as io");
    chk("R7 io no mem", 32'(rsp_hit), 0);
    req(32'h0000_0001, 1'b0, "R10 total miss");
    chk("R10 addr zero", rsp_addr, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      int w;
      if ($urandom_range(0, 7) == 0)
        wr(3'($urandom_range(0, 7)), $urandom());
      w = $urandom_range(0, 4);
      if (w < 3) begin
        a = {s_pb[w], 20'($urandom())};
        if ($urandom_range(0, 1) == 1) a[28:20] = a[28:20] ^ 9'($urandom());
        req(a, 1'b0, "R3 R4 R9 random mem");
      end else if (w == 3) begin
        a = {s_iopb, 8'($urandom())};
        if ($urandom_range(0, 3) == 0) a[8] = ~a[8];
        req(a, ($urandom_range(0, 5) != 0), "R5 R7 random io");
      end else begin
        req($urandom(), 1'($urandom()), "R10 random any");
      end
    end

    // R1 reset again clears windows
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    shadow_clear();
    chk("R1 reset addr", rsp_addr, 0);
    req(32'h400A_BCDE, 1'b0, "R1 disabled after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule